// File: doc/BRIEF.md
# Dual-Format PWM Generator

This block is one pulse-width modulation channel. It advances only on clocks where the count-source enable `tick` is high, so the tick rate sets its time base. A single full-width write loads a setting word. The format pin then decides how that word is read when the next period begins.

In wide format the whole word is the high time, inside a period of 2^W − 1 ticks. In split format the upper half of the word is the duty. The lower half is a prescaler that stretches every slot of a shorter 2^(W/2) − 1 slot frame. This gives coarser steps but a much longer period.

The setting and the format take effect only at a period boundary. A zero duty parks the channel: the output stays low and no interrupts are raised. One interrupt pulse per period marks the clock edge on which the output drops.

Top module: `pwm_dual_fmt`

## Requirements
- R1: After reset `pwm_out` and `irq` are low and the channel is idle. A nonzero setting written while idle does nothing until the next tick. That tick starts a period, with `pwm_out` high from the clock edge that samples it.
- R2: With `fmt_sel` = 0 (wide format), a period lasts 2^W − 1 ticks. `pwm_out` is high for the first n ticks of the period, where n is the whole setting word.
- R3: With `fmt_sel` = 1 (split format), m is bits [W/2−1:0] of the setting and n is bits [W−1:W/2]. A period lasts (2^(W/2) − 1)·(m + 1) ticks, and `pwm_out` is high for its first n·(m + 1) ticks.
- R4: A zero duty keeps `pwm_out` low, raises no `irq` and leaves the channel idle. Zero duty means a zero word in wide format, or a zero upper half in split format. A zero written during a running period stops the channel only when that period ends.
- R5: The setting word and `fmt_sel` are sampled only when a period starts. Writes and format changes made during a period do not alter that period; they govern the next one.
- R6: `irq` is a single-clock pulse, given once per period, on the same clock edge where `pwm_out` falls.
- R7: A duty equal to the period's slot count holds `pwm_out` high with no `irq`. That means an all-ones word in wide format, or an all-ones upper half in split format.
- R8: On clocks with `tick` low, neither `pwm_out` nor the period position changes, and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-source enable, one clock per tick |
| wr_en | input | 1 | Write strobe for the setting word |
| wr_data | input | CNT_W | Setting word |
| fmt_sel | input | 1 | Format select: 0 wide, 1 split |
| pwm_out | output | 1 | Registered PWM level |
| irq | output | 1 | Period interrupt pulse, registered |

## Verification
The bench builds the channel with CNT_W = 8. That gives a wide period of 255 ticks and a split frame of 15 slots of up to 16 ticks each. At this size every one of the 256 split-format settings can be run for a full period and checked against n·(m+1) high ticks and an interrupt at tick n·(m+1)+1. The wide format is swept in steps of 15 plus the edge values 1 and 254. Directed runs cover the mid-period write, the format change, the stop to zero and gaps in the tick stream.

// File: rtl/pwm_fmt_pkg.sv
package pwm_fmt_pkg;
  typedef enum logic {
    FMT_WIDE  = 1'b0,
    FMT_SPLIT = 1'b1
  } pwm_fmt_e;
endpackage

// File: rtl/pwm_shadow.sv
// Holds the written setting and copies it, with the format, into the
// active set only on a period load.
module pwm_shadow
  import pwm_fmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HALF_W = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             fmt_split,
  input  logic             load,
  output logic [CNT_W-1:0] act_val,
  output pwm_fmt_e         act_fmt,
  output logic             pend_go
);
  logic [CNT_W-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      act_val <= '0;
      act_fmt <= FMT_WIDE;
    end else begin
      if (wr_en) pend_q <= wr_data;
      if (load) begin
        act_val <= pend_q;
        act_fmt <= fmt_split ? FMT_SPLIT : FMT_WIDE;
      end
    end
  end

  // Nonzero duty in the format that would be latched now.
  assign pend_go = fmt_split ? (|pend_q[CNT_W-1:HALF_W]) : (|pend_q);

  // R5: the active setting moves only on a load.
  a_r5_hold_between_loads: assert property (@(posedge clk) disable iff (rst)
    (!load && !wr_en) |=> ($stable(act_val) && $stable(act_fmt)));
endmodule

// File: rtl/pwm_prescale.sv
// Stretches each slot to limit+1 ticks in split format; passes ticks in wide format.
module pwm_prescale #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick_run,
  input  logic              split,
  input  logic [HALF_W-1:0] limit,
  output logic              step
);
  logic [HALF_W-1:0] pre_q;
  logic              hit;

  assign hit  = (pre_q == limit);
  assign step = tick_run & (~split | hit);

  always_ff @(posedge clk) begin
    if (rst || clr)              pre_q <= '0;
    else if (tick_run && split)  pre_q <= hit ? '0 : pre_q + 1'b1;
  end

  // R3: the prescaler never runs past its limit.
  a_r3_pre_bound: assert property (@(posedge clk) disable iff (rst)
    split |-> (pre_q <= limit));
endmodule

// File: rtl/pwm_slot_ctr.sv
// Slot position inside the current period.
module pwm_slot_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] last,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nx,
  output logic             at_last
);
  assign cnt_nx  = cnt + 1'b1;
  assign at_last = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step)  cnt <= cnt_nx;
  end

  // R2: the position stays inside the frame.
  a_r2_cnt_in_frame: assert property (@(posedge clk) disable iff (rst)
    cnt <= last);
endmodule

// File: rtl/pwm_dual_fmt.sv
module pwm_dual_fmt
  import pwm_fmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             fmt_sel,
  output logic             pwm_out,
  output logic             irq
);
  localparam int HALF_W = CNT_W / 2;
  localparam logic [CNT_W-1:0] WIDE_LAST  = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam logic [CNT_W-1:0] SPLIT_LAST =
    {{(CNT_W-HALF_W){1'b0}}, {(HALF_W-1){1'b1}}, 1'b0};

  generate
    if ((CNT_W % 2) != 0 || CNT_W < 4) begin : g_bad_width
      $error("pwm_dual_fmt: CNT_W must be even and at least 4");
    end
  endgenerate

  logic [CNT_W-1:0] act_val, cnt, cnt_nx, duty, last;
  pwm_fmt_e         act_fmt;
  logic             split, pend_go, at_last;
  logic             run_q, pwm_q, irq_q;
  logic             tick_run, start, step, wrap, load;

  assign split    = (act_fmt == FMT_SPLIT);
  assign duty     = split ? {{(CNT_W-HALF_W){1'b0}}, act_val[CNT_W-1:HALF_W]} : act_val;
  assign last     = split ? SPLIT_LAST : WIDE_LAST;
  assign tick_run = tick & run_q;
  assign start    = tick & ~run_q & pend_go;
  assign wrap     = step & at_last;
  assign load     = start | wrap;

  pwm_shadow #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_shadow (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .fmt_split(fmt_sel), .load(load),
    .act_val(act_val), .act_fmt(act_fmt), .pend_go(pend_go)
  );

  pwm_prescale #(.HALF_W(HALF_W)) u_pre (
    .clk(clk), .rst(rst), .clr(load), .tick_run(tick_run),
    .split(split), .limit(act_val[HALF_W-1:0]), .step(step)
  );

  pwm_slot_ctr #(.CNT_W(CNT_W)) u_slot (
    .clk(clk), .rst(rst), .clr(load), .step(step), .last(last),
    .cnt(cnt), .cnt_nx(cnt_nx), .at_last(at_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      pwm_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= step & ~at_last & (cnt_nx == duty);
      if (load) begin
        run_q <= pend_go;
        pwm_q <= pend_go;
      end else if (step && (cnt_nx == duty)) begin
        pwm_q <= 1'b0;
      end
    end
  end

  assign pwm_out = pwm_q;
  assign irq     = irq_q;

  // R6: interrupt marks the falling edge of the output.
  a_r6_irq_on_fall: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!pwm_out && $past(pwm_out)));
  // R4: an idle channel drives low.
  a_r4_idle_low: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (!pwm_out && !irq));
  // R8: without a tick nothing moves.
  a_r8_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(pwm_out) && $stable(cnt) && !irq));
  // R7: a full-frame duty never raises an interrupt.
  a_r7_full_no_irq: assert property (@(posedge clk) disable iff (rst)
    (run_q && duty == last + 1'b1) |=> !irq);
endmodule

// File: tb/sim_pwm_dual_fmt.sv
module sim_pwm_dual_fmt;
  localparam int W  = 8;
  localparam int PW = 255;
  localparam int PS = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic fmt_sel = 1'b0;
  logic pwm_out, irq;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pwm_dual_fmt #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .fmt_sel(fmt_sel), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_set(input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = W'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic measure(input int len, output int hi, output int nirq, output int firq);
    hi = 0; nirq = 0; firq = 0;
    for (int t = 1; t <= len; t++) begin
      tick_once();
      if (pwm_out) hi++;
      if (irq) begin
        nirq++;
        if (firq == 0) firq = t;
      end
    end
  endtask

  task automatic run_case(input bit sp, input int val);
    int m, n, p, len, hi, ni, fi, ei;
    string tg, ti;
    do_reset();
    fmt_sel = sp;
    write_set(val);
    if (sp) begin m = val % 16; n = val / 16; p = PS; end
    else    begin m = 0;        n = val;      p = PW; end
    len = p * (m + 1);
    measure(len, hi, ni, fi);
    tg = (n == 0) ? "R4" : (n == p) ? "R7" : (sp ? "R3" : "R2");
    ti = (n == 0) ? "R4" : (n == p) ? "R7" : "R6";
    ei = (n != 0 && n != p) ? 1 : 0;
    chk(tg, $sformatf("high ticks fmt=%0d set=%0d", sp, val), hi, n * (m + 1));
    chk(ti, $sformatf("irq count fmt=%0d set=%0d", sp, val), ni, ei);
    if (ei == 1)
      chk("R6", $sformatf("irq tick fmt=%0d set=%0d", sp, val), fi, n * (m + 1) + 1);
    tick_once();
    chk(tg, $sformatf("next period level fmt=%0d set=%0d", sp, val), int'(pwm_out), (n != 0) ? 1 : 0);
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int hi, ni, fi, bad;

    // R1 reset state and start on first tick
    do_reset();
    chk("R1", "pwm after reset", int'(pwm_out), 0);
    chk("R1", "irq after reset", int'(irq), 0);
    fmt_sel = 1'b0;
    write_set(5);
    chk("R1", "pwm before first tick", int'(pwm_out), 0);
    tick_once();
    chk("R1", "pwm after first tick", int'(pwm_out), 1);

    // R8 gap in ticks
    bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (!pwm_out || irq) bad++;
    end
    chk("R8", "changes without tick", bad, 0);
    measure(254, hi, ni, fi);
    chk("R8", "high ticks after gap", hi, 4);
    chk("R8", "irq tick after gap", fi, 5);

    // R5 mid-period write and format change
    do_reset();
    fmt_sel = 1'b0;
    write_set(10);
    measure(3, hi, ni, fi);
    fmt_sel = 1'b1;
    write_set(8'h31);
    measure(252, hi, ni, fi);
    chk("R5", "old period high rest", hi, 7);
    chk("R5", "old period irq tick", fi, 8);
    measure(30, hi, ni, fi);
    chk("R5", "new period high", hi, 6);
    chk("R5", "new period irq count", ni, 1);
    chk("R5", "new period irq tick", fi, 7);

    // R4 zero written mid-period stops at period end
    do_reset();
    fmt_sel = 1'b0;
    write_set(10);
    measure(3, hi, ni, fi);
    write_set(0);
    measure(252, hi, ni, fi);
    chk("R4", "period finishes high", hi, 7);
    chk("R4", "period finishes irq", ni, 1);
    measure(300, hi, ni, fi);
    chk("R4", "stopped high", hi, 0);
    chk("R4", "stopped irq", ni, 0);

    // wide format sweep
    for (int v = 0; v < 256; v += 15) run_case(1'b0, v);
    run_case(1'b0, 1);
    run_case(1'b0, 254);

    // split format exhaustive sweep
    for (int v = 0; v < 256; v++) run_case(1'b1, v);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule